// File: doc/BRIEF.md
# Oversampling Serial Receiver with Three-Sample Voting

This block receives asynchronous serial frames on a single line. An external divider supplies a one-cycle enable (`baud_tick`) at the oversampling rate. A mode input selects one of two rates: 16 ticks per bit (normal) or 8 ticks per bit (double speed). The line passes through a flop synchronizer first. A falling level seen while idle opens a frame. Each bit, including the start and stop bits, is then decided by a majority of three consecutive samples around the bit centre.

A frame carries 5 to 9 data bits, least significant first, then an optional parity bit and one stop bit. When the stop bit has been voted, the block presents the data right-aligned, with a one-cycle valid strobe and two error flags. The flags and the data hold until the next frame completes. The receiver re-arms as soon as the stop-bit vote ends, so a sender with a short stop bit is still followed. In double-speed mode, the first tick after the stop vote is skipped before the line is watched for a new start.

Top module: `uart_vote_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_data`, `frame_err` and `parity_err` are all zero.
- R2: With `double_speed`=0 a bit lasts 16 ticks. Counting the first low start sample as sample 1, samples 8, 9 and 10 of each bit are voted. Data is taken least significant bit first and presented right-aligned, with unused upper bits zero.
- R3: With `double_speed`=1 a bit lasts 8 ticks and samples 4, 5 and 6 are voted.
- R4: A bit value equals the majority of its three voted samples. Samples outside the vote window have no effect. One disagreeing voted sample does not change the bit. Two disagreeing voted samples flip it.
- R5: A start bit whose vote resolves to 1 is discarded as a glitch. No strobe is produced, and the receiver waits for the next low sample.
- R6: `data_bits` selects 5 to 9 data bits per frame. Values below 5 act as 5 and values above 9 act as 9.
- R7: `parity_mode` 2'b01 expects even parity and 2'b10 expects odd parity, with a parity bit sent after the data. 2'b00 and 2'b11 mean no parity bit, and `parity_err` stays 0. A mismatch sets `parity_err` for that frame.
- R8: A stop bit voted as 0 sets `frame_err` for that frame. The data is still delivered with the strobe.
- R9: `rx_valid` is high for exactly one clock, in the cycle after the tick that carries the last stop-bit vote sample. `rx_data` and both flags change only together with the strobe.
- R10: In normal mode, a low sample on the tick right after the stop vote starts a new frame. In double-speed mode, that one tick is ignored and start detection resumes on the following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| baud_tick | input | 1 | One-cycle oversampling enable |
| double_speed | input | 1 | 1 = 8 ticks per bit, 0 = 16 ticks per bit |
| data_bits | input | 4 | Data bits per frame (5..9) |
| parity_mode | input | 2 | 00/11 none, 01 even, 10 odd |
| rx_data | output | 9 | Received data, right-aligned |
| rx_valid | output | 1 | One-cycle frame-complete strobe |
| frame_err | output | 1 | Stop bit of last frame voted 0 |
| parity_err | output | 1 | Parity mismatch in last frame |

## Verification
The bench builds the block with its defaults: up to 9 data bits, 16 and 8 samples per bit, and a two-stage synchronizer. It drives `baud_tick` once every four clocks. Because the synchronizer delay is shorter than one tick, each line value the bench sets lands on exactly one known sample index. This lets the bench flip single samples inside and outside the vote window, and cut the stop bit to the last voted sample. It can also place a low pulse exactly on the tick that double-speed mode skips, where a receiver without that skip would start a spurious frame.

// File: rtl/uart_vote_pkg.sv
package uart_vote_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_HOLD
   } rx_state_t;

   typedef enum logic [1:0] {
      PAR_NONE     = 2'b00,
      PAR_EVEN     = 2'b01,
      PAR_ODD      = 2'b10,
      PAR_NONE_ALT = 2'b11
   } par_mode_t;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/uart_vote_sync.sv
module uart_vote_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("uart_vote_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/uart_vote_sampler.sv
module uart_vote_sampler
   import uart_vote_pkg::*;
#(
   parameter int NORM_OS = 16,
   parameter int DBL_OS  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rx_s,
   input  logic double_speed,
   input  logic arm,
   output logic start_seen,
   output logic vote_valid,
   output logic vote_bit
);

   localparam int IDX_W = $clog2(NORM_OS + 1);
   localparam logic [IDX_W-1:0] OS_N  = IDX_W'(NORM_OS);
   localparam logic [IDX_W-1:0] OS_D  = IDX_W'(DBL_OS);
   localparam logic [IDX_W-1:0] ONE   = IDX_W'(1);

   logic [IDX_W-1:0] os, first_idx, mid_idx, last_idx;
   logic [IDX_W-1:0] idx, cur_idx;
   logic             v_a, v_b;

   assign os        = double_speed ? OS_D : OS_N;
   assign first_idx = os >> 1;
   assign mid_idx   = first_idx + ONE;
   assign last_idx  = first_idx + IDX_W'(2);

   always_comb begin
      if (arm)             cur_idx = ONE;
      else if (idx >= os)  cur_idx = ONE;
      else                 cur_idx = idx + ONE;
   end

   assign start_seen = tick & arm & ~rx_s;
   assign vote_valid = tick & ~arm & (cur_idx == last_idx);
   assign vote_bit   = maj3(v_a, v_b, rx_s);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= ONE;
         v_a <= 1'b1;
         v_b <= 1'b1;
      end else if (tick) begin
         if (!arm) begin
            idx <= cur_idx;
            if (cur_idx == first_idx) v_a <= rx_s;
            if (cur_idx == mid_idx)   v_b <= rx_s;
         end else if (!rx_s) begin
            idx <= ONE;
         end
      end
   end

endmodule

// File: rtl/uart_vote_ctrl.sv
module uart_vote_ctrl
   import uart_vote_pkg::*;
#(
   parameter int MAX_DATA_BITS = 9,
   localparam int DBITS_W = $clog2(MAX_DATA_BITS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  logic                     double_speed,
   input  logic [DBITS_W-1:0]       data_bits,
   input  logic [1:0]               parity_mode,
   input  logic                     start_seen,
   input  logic                     vote_valid,
   input  logic                     vote_bit,
   output logic                     arm,
   output logic [MAX_DATA_BITS-1:0] rx_data,
   output logic                     rx_valid,
   output logic                     frame_err,
   output logic                     parity_err
);

   localparam logic [DBITS_W-1:0] MIN_N = DBITS_W'(5);
   localparam logic [DBITS_W-1:0] MAX_N = DBITS_W'(MAX_DATA_BITS);

   rx_state_t                state;
   logic [DBITS_W-1:0]       nbits, bit_cnt;
   logic [MAX_DATA_BITS-1:0] shreg;
   logic                     par_acc, par_bad, par_on;

   always_comb begin
      if (data_bits < MIN_N)      nbits = MIN_N;
      else if (data_bits > MAX_N) nbits = MAX_N;
      else                        nbits = data_bits;
   end

   assign par_on = (parity_mode == PAR_EVEN) || (parity_mode == PAR_ODD);
   assign arm    = (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bit_cnt    <= '0;
         shreg      <= '0;
         par_acc    <= 1'b0;
         par_bad    <= 1'b0;
         rx_data    <= '0;
         rx_valid   <= 1'b0;
         frame_err  <= 1'b0;
         parity_err <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         unique case (state)
            ST_IDLE: if (start_seen) state <= ST_START;
            ST_START: if (vote_valid) begin
               if (vote_bit) begin
                  state <= ST_IDLE;
               end else begin
                  state   <= ST_DATA;
                  bit_cnt <= '0;
                  shreg   <= '0;
                  par_acc <= 1'b0;
                  par_bad <= 1'b0;
               end
            end
            ST_DATA: if (vote_valid) begin
               shreg[bit_cnt] <= vote_bit;
               par_acc        <= par_acc ^ vote_bit;
               if (bit_cnt == nbits - DBITS_W'(1))
                  state <= par_on ? ST_PAR : ST_STOP;
               else
                  bit_cnt <= bit_cnt + DBITS_W'(1);
            end
            ST_PAR: if (vote_valid) begin
               par_bad <= (parity_mode == PAR_EVEN) ? (vote_bit != par_acc)
                                                    : (vote_bit == par_acc);
               state   <= ST_STOP;
            end
            ST_STOP: if (vote_valid) begin
               rx_valid   <= 1'b1;
               rx_data    <= shreg;
               frame_err  <= ~vote_bit;
               parity_err <= par_bad;
               state      <= double_speed ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: if (tick) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
   import uart_vote_pkg::*;
#(
   parameter int MAX_DATA_BITS = 9,
   parameter int NORM_OS       = 16,
   parameter int DBL_OS        = 8,
   parameter int SYNC_STAGES   = 2,
   localparam int DBITS_W = $clog2(MAX_DATA_BITS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rxd,
   input  logic                     baud_tick,
   input  logic                     double_speed,
   input  logic [DBITS_W-1:0]       data_bits,
   input  logic [1:0]               parity_mode,
   output logic [MAX_DATA_BITS-1:0] rx_data,
   output logic                     rx_valid,
   output logic                     frame_err,
   output logic                     parity_err
);

   generate
      if (MAX_DATA_BITS < 5 || MAX_DATA_BITS > 9) begin : g_bad_width
         $error("uart_vote_rx: MAX_DATA_BITS must lie in 5..9");
      end
      if (NORM_OS < 6 || (NORM_OS % 2) != 0) begin : g_bad_norm
         $error("uart_vote_rx: NORM_OS must be even and at least 6");
      end
      if (DBL_OS < 6 || (DBL_OS % 2) != 0 || DBL_OS > NORM_OS) begin : g_bad_dbl
         $error("uart_vote_rx: DBL_OS must be even, at least 6, not above NORM_OS");
      end
   endgenerate

   logic rx_s, arm, start_seen, vote_valid, vote_bit;

   uart_vote_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rxd),
      .dout (rx_s)
   );

   uart_vote_sampler #(.NORM_OS(NORM_OS), .DBL_OS(DBL_OS)) smp_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (baud_tick),
      .rx_s        (rx_s),
      .double_speed(double_speed),
      .arm         (arm),
      .start_seen  (start_seen),
      .vote_valid  (vote_valid),
      .vote_bit    (vote_bit)
   );

   uart_vote_ctrl #(.MAX_DATA_BITS(MAX_DATA_BITS)) ctl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (baud_tick),
      .double_speed(double_speed),
      .data_bits   (data_bits),
      .parity_mode (parity_mode),
      .start_seen  (start_seen),
      .vote_valid  (vote_valid),
      .vote_bit    (vote_bit),
      .arm         (arm),
      .rx_data     (rx_data),
      .rx_valid    (rx_valid),
      .frame_err   (frame_err),
      .parity_err  (parity_err)
   );

endmodule

// File: rtl/uart_vote_rx_chk.sv
module uart_vote_rx_chk #(
   parameter int MAX_DATA_BITS = 9,
   localparam int DBITS_W = $clog2(MAX_DATA_BITS + 1)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     baud_tick,
   input logic [DBITS_W-1:0]       data_bits,
   input logic [1:0]               parity_mode,
   input logic [MAX_DATA_BITS-1:0] rx_data,
   input logic                     rx_valid,
   input logic                     frame_err,
   input logic                     parity_err
);

   p_valid_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_outputs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> ($stable(rx_data) && $stable(frame_err) && $stable(parity_err)));

   p_strobe_follows_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(baud_tick));

   p_no_parity_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && ($past(parity_mode) == 2'b00 || $past(parity_mode) == 2'b11))
      |-> !parity_err);

   p_upper_bits_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && $past(data_bits) == DBITS_W'(5)) |-> ((rx_data >> 5) == '0));

endmodule

bind uart_vote_rx uart_vote_rx_chk #(.MAX_DATA_BITS(MAX_DATA_BITS)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .baud_tick  (baud_tick),
   .data_bits  (data_bits),
   .parity_mode(parity_mode),
   .rx_data    (rx_data),
   .rx_valid   (rx_valid),
   .frame_err  (frame_err),
   .parity_err (parity_err)
);

// File: tb/uart_vote_rx_tb.sv
module uart_vote_rx_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       baud_tick = 1'b0;
   logic       double_speed = 1'b0;
   logic [3:0] data_bits = 4'd8;
   logic [1:0] parity_mode = 2'b00;
   logic [8:0] rx_data;
   logic       rx_valid, frame_err, parity_err;

   int total = 0;
   int bad = 0;
   int nvalid = 0;
   int tick_cnt = 0;
   bit prev_v = 1'b0;
   bit multi = 1'b0;
   logic [8:0] got_d  [0:63];
   logic       got_fe [0:63];
   logic       got_pe [0:63];

   uart_vote_rx dut_i (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
      .double_speed(double_speed), .data_bits(data_bits), .parity_mode(parity_mode),
      .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err), .parity_err(parity_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (!rst_n) begin
         tick_cnt  = 0;
         baud_tick = 1'b0;
      end else begin
         tick_cnt  = (tick_cnt + 1) % TICK_DIV;
         baud_tick = (tick_cnt == 0);
      end
   end

   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         if (nvalid < 64) begin
            got_d[nvalid]  = rx_data;
            got_fe[nvalid] = frame_err;
            got_pe[nvalid] = parity_err;
         end
         nvalid++;
      end
      if (rx_valid && prev_v) multi = 1'b1;
      prev_v = rx_valid;
   end

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_tick();
      do @(posedge clk); while (baud_tick !== 1'b1);
      @(negedge clk);
   endtask

   function automatic int os_len();
      return double_speed ? 8 : 16;
   endfunction

   task automatic send_bit(input logic v, input logic [15:0] mask);
      for (int i = 0; i < os_len(); i++) begin
         rxd = v ^ mask[i];
         wait_tick();
      end
   endtask

   task automatic idle(input int n);
      rxd = 1'b1;
      repeat (n) wait_tick();
   endtask

   task automatic send_frame(input logic [8:0] d, input int nb, input bit pen,
                             input logic pbit, input logic stop_v, input int stop_len,
                             input int flip_idx, input logic [15:0] flip_mask);
      send_bit(1'b0, 16'h0);
      for (int i = 0; i < nb; i++)
         send_bit(d[i], (i == flip_idx) ? flip_mask : 16'h0);
      if (pen) send_bit(pbit, 16'h0);
      rxd = stop_v;
      repeat (stop_len) wait_tick();
   endtask

   function automatic logic xr(input logic [8:0] d, input int nb);
      logic p = 1'b0;
      for (int i = 0; i < nb; i++) p ^= d[i];
      return p;
   endfunction

   task automatic expect_frame(input string req, input int idx, input logic [8:0] d,
                               input logic fe, input logic pe);
      chk(req, "strobe count", nvalid, idx + 1);
      chk(req, "data", got_d[idx], d);
      chk(req, "frame_err", got_fe[idx], fe);
      chk(req, "parity_err", got_pe[idx], pe);
   endtask

   task automatic cfg(input bit dbl, input int nb, input logic [1:0] pm);
      double_speed = dbl;
      data_bits    = 4'(nb);
      parity_mode  = pm;
      idle(3);
   endtask

   task automatic t_reset();
      chk("R1", "rx_valid", rx_valid, 0);
      chk("R1", "rx_data", rx_data, 0);
      chk("R1", "frame_err", frame_err, 0);
      chk("R1", "parity_err", parity_err, 0);
   endtask

   task automatic t_normal();
      int b;
      cfg(0, 8, 2'b00);
      b = nvalid;
      send_frame(9'h0A5, 8, 0, 0, 1, 16, -1, 0); idle(4);
      expect_frame("R2", b, 9'h0A5, 0, 0);
      send_frame(9'h03C, 8, 0, 0, 1, 16, -1, 0); idle(4);
      expect_frame("R2", b + 1, 9'h03C, 0, 0);
   endtask

   task automatic t_double();
      int b;
      cfg(1, 8, 2'b00);
      b = nvalid;
      send_frame(9'h05A, 8, 0, 0, 1, 8, -1, 0); idle(4);
      expect_frame("R3", b, 9'h05A, 0, 0);
      send_frame(9'h0C3, 8, 0, 0, 1, 8, -1, 0); idle(4);
      expect_frame("R3", b + 1, 9'h0C3, 0, 0);
   endtask

   task automatic t_width();
      int b;
      cfg(0, 5, 2'b00);
      b = nvalid;
      send_frame(9'h013, 5, 0, 0, 1, 16, -1, 0); idle(4);
      expect_frame("R6", b, 9'h013, 0, 0);
      cfg(0, 9, 2'b00);
      send_frame(9'h1A5, 9, 0, 0, 1, 16, -1, 0); idle(4);
      expect_frame("R6", b + 1, 9'h1A5, 0, 0);
      cfg(0, 2, 2'b00);
      send_frame(9'h00A, 5, 0, 0, 1, 16, -1, 0); idle(4);
      expect_frame("R6 clamp-low", b + 2, 9'h00A, 0, 0);
      cfg(0, 7, 2'b00);
      send_frame(9'h055, 7, 0, 0, 1, 16, -1, 0); idle(4);
      expect_frame("R6", b + 3, 9'h055, 0, 0);
   endtask

   task automatic t_parity();
      int b;
      cfg(0, 8, 2'b01);
      b = nvalid;
      send_frame(9'h096, 8, 1, xr(9'h096, 8), 1, 16, -1, 0); idle(4);
      expect_frame("R7 even ok", b, 9'h096, 0, 0);
      send_frame(9'h097, 8, 1, ~xr(9'h097, 8), 1, 16, -1, 0); idle(4);
      expect_frame("R7 even bad", b + 1, 9'h097, 0, 1);
      cfg(0, 8, 2'b10);
      send_frame(9'h096, 8, 1, ~xr(9'h096, 8), 1, 16, -1, 0); idle(4);
      expect_frame("R7 odd ok", b + 2, 9'h096, 0, 0);
      send_frame(9'h011, 8, 1, xr(9'h011, 8), 1, 16, -1, 0); idle(4);
      expect_frame("R7 odd bad", b + 3, 9'h011, 0, 1);
      cfg(0, 8, 2'b11);
      send_frame(9'h0E1, 8, 0, 0, 1, 16, -1, 0); idle(4);
      expect_frame("R7 mode3 none", b + 4, 9'h0E1, 0, 0);
   endtask

   task automatic t_frame_err();
      int b;
      cfg(0, 8, 2'b00);
      b = nvalid;
      send_frame(9'h0F0, 8, 0, 0, 0, 16, -1, 0); idle(40);
      expect_frame("R8", b, 9'h0F0, 1, 0);
      send_frame(9'h00F, 8, 0, 0, 1, 16, -1, 0); idle(4);
      expect_frame("R8 cleared", b + 1, 9'h00F, 0, 0);
   endtask

   task automatic t_majority();
      int b;
      cfg(0, 8, 2'b00);
      b = nvalid;
      send_frame(9'h000, 8, 0, 0, 1, 16, 2, 16'h0100); idle(4);
      expect_frame("R4 one flip", b, 9'h000, 0, 0);
      send_frame(9'h000, 8, 0, 0, 1, 16, 2, 16'h0180); idle(4);
      expect_frame("R4 two flips", b + 1, 9'h004, 0, 0);
      send_frame(9'h000, 8, 0, 0, 1, 16, 2, 16'hFC7F); idle(4);
      expect_frame("R4 outside window", b + 2, 9'h000, 0, 0);
   endtask

   task automatic t_glitch();
      int b;
      cfg(0, 8, 2'b00);
      b = nvalid;
      rxd = 1'b0; repeat (3) wait_tick();
      idle(60);
      chk("R5", "no strobe after short low (normal)", nvalid, b);
      cfg(1, 8, 2'b00);
      rxd = 1'b0; repeat (2) wait_tick();
      idle(40);
      chk("R5", "no strobe after short low (double)", nvalid, b);
      send_frame(9'h069, 8, 0, 0, 1, 8, -1, 0); idle(4);
      expect_frame("R5 recovers", b, 9'h069, 0, 0);
   endtask

   task automatic t_hold();
      int b;
      cfg(0, 8, 2'b01);
      b = nvalid;
      send_frame(9'h0B4, 8, 1, ~xr(9'h0B4, 8), 0, 16, -1, 0);
      idle(100);
      chk("R9", "strobes in frame", nvalid, b + 1);
      chk("R9", "data held", rx_data, 9'h0B4);
      chk("R9", "parity_err held", parity_err, 1);
      chk("R9", "frame_err held", frame_err, 1);
      chk("R9", "strobe one cycle", multi, 0);
   endtask

   task automatic t_rearm();
      int b;
      cfg(0, 8, 2'b00);
      b = nvalid;
      send_frame(9'h0C6, 8, 0, 0, 1, 10, -1, 0);
      send_frame(9'h039, 8, 0, 0, 1, 16, -1, 0); idle(4);
      chk("R10", "normal back-to-back count", nvalid, b + 2);
      chk("R10", "normal first data", got_d[b], 9'h0C6);
      chk("R10", "normal second data", got_d[b + 1], 9'h039);
      cfg(1, 8, 2'b00);
      b = nvalid;
      send_frame(9'h0AA, 8, 0, 0, 1, 6, -1, 0);
      rxd = 1'b0; repeat (5) wait_tick();
      idle(40);
      chk("R10", "double skipped tick", nvalid, b + 1);
      chk("R10", "double data", got_d[b], 9'h0AA);
      b = nvalid;
      send_frame(9'h081, 8, 0, 0, 1, 6, -1, 0);
      send_frame(9'h07E, 8, 0, 0, 1, 8, -1, 0); idle(4);
      chk("R10", "double back-to-back count", nvalid, b + 2);
      chk("R10", "double second data", got_d[b + 1], 9'h07E);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_normal();
      t_double();
      t_width();
      t_parity();
      t_frame_err();
      t_majority();
      t_glitch();
      t_hold();
      t_rearm();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 190000);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule